// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm Interrupts

This block is a memory-mapped real-time clock. A slow timebase pulse advances a millisecond counter. Each time that counter completes a full second, it carries into a 32-bit seconds counter. Two seconds compare registers and one millisecond compare register record match events in a sticky status register. A mask register selects which status bits drive a level-high interrupt line.

Software reaches the block through a simple 32-bit register bus. Register reads are combinational. Register writes take effect on the clock edge.

Writes model the commit into a slow clock domain. Every accepted write holds a busy flag high for a parameterised number of timebase pulses. Any write that arrives while the flag is high is dropped.

Reading the millisecond register latches the current seconds value into a shadow register. Software can then read the shadow register and get a seconds value that matches the milliseconds it just read.

Top module: `rtc_secs_alarm`

## Requirements
- R1: After reset, every readable register reads 0, including busy at 0x004. `irq_o` is 0.
- R2: Each `tick_i` pulse advances the milliseconds value at 0x010 by one. After MS_PER_SEC-1 the next pulse gives 0 and adds one to the seconds value at 0x008 on that same pulse.
- R3: The seconds counter is 32 bits wide. A carry from 0xFFFFFFFF gives 0.
- R4: An accepted write to 0x008 loads the seconds counter. The milliseconds value is left unchanged.
- R5: A read of 0x010 copies the seconds value of that cycle into the shadow register. Later reads of 0x00C return that copy until the next read of 0x010.
- R6: An accepted write to any writable offset (0x008, 0x014, 0x018, 0x01C, 0x028, 0x02C) sets bit 0 of 0x004. The bit stays set until BUSY_TICKS further `tick_i` pulses have arrived.
- R7: A write that arrives while bit 0 of 0x004 is 1 is ignored. It has no effect on any register.
- R8: Status bit k (k=0 for the alarm at 0x014, k=1 for the alarm at 0x018) becomes 1 when a carry moves the seconds counter onto that alarm value. An alarm value of 0 never fires.
- R9: Status bit 2 becomes 1 when a pulse moves the milliseconds counter onto the value held at 0x01C.
- R10: The status register at 0x02C is write-one-to-clear. A bit set by an event in the same cycle as its clear stays 1. Bits 3 and 4 (the countdown alarm positions) and bits 31:5 always read 0.
- R11: The mask register at 0x028 holds 5 bits and its upper bits read 0. `irq_o` is 1 exactly when some status bit and the mask bit at the same position are both 1.
- R12: Writes to the read-only offsets (0x004, 0x00C, 0x010) and to unmapped offsets change nothing and do not set busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle timebase pulse, one per millisecond |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected offset |
| irq_o | output | 1 | Level-high interrupt |

## Verification
The bench builds the block with MS_PER_SEC=8 and BUSY_TICKS=2.

With these values a second ends after only eight pulses. Every millisecond value, several carries and the wrap of the seconds counter from 0xFFFFFFFF can therefore be swept completely in a few hundred cycles. The same applies to alarm matches on both seconds compares and on every millisecond position.

The short busy window lets the bench count the exact pulse on which busy falls. It also lets the bench check that a write dropped in the middle of that window leaves its register unchanged.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int NUM_SEC_ALM = 2;
    localparam int INT_W       = 5;

    localparam logic [ADDR_W-1:0] REG_BUSY   = 8'h04;
    localparam logic [ADDR_W-1:0] REG_SEC    = 8'h08;
    localparam logic [ADDR_W-1:0] REG_SHADOW = 8'h0C;
    localparam logic [ADDR_W-1:0] REG_MS     = 8'h10;
    localparam logic [ADDR_W-1:0] REG_ALM0   = 8'h14;
    localparam logic [ADDR_W-1:0] REG_ALM1   = 8'h18;
    localparam logic [ADDR_W-1:0] REG_MSALM  = 8'h1C;
    localparam logic [ADDR_W-1:0] REG_MASK   = 8'h28;
    localparam logic [ADDR_W-1:0] REG_STAT   = 8'h2C;

    localparam int BIT_ALM0  = 0;
    localparam int BIT_ALM1  = 1;
    localparam int BIT_MSALM = 2;

    function automatic logic is_writable(input logic [ADDR_W-1:0] a);
        return (a == REG_SEC)   || (a == REG_ALM0) || (a == REG_ALM1) ||
               (a == REG_MSALM) || (a == REG_MASK) || (a == REG_STAT);
    endfunction
endpackage

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
#(
    parameter int MS_PER_SEC = 1000,
    parameter int MS_W       = $clog2(MS_PER_SEC)
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               tick_i,
    input  logic                               sec_load_i,
    input  logic [DATA_W-1:0]                  sec_wdata_i,
    input  logic [NUM_SEC_ALM-1:0][DATA_W-1:0] sec_alm_i,
    input  logic [MS_W-1:0]                    ms_alm_i,
    output logic [DATA_W-1:0]                  sec_o,
    output logic [MS_W-1:0]                    ms_o,
    output logic [NUM_SEC_ALM-1:0]             sec_hit_o,
    output logic                               ms_hit_o
);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [MS_W-1:0]   ms;
    } tk_t;

    tk_t st_d, st_q;
    logic              carry;
    logic [MS_W-1:0]   ms_next;
    logic [DATA_W-1:0] sec_next;

    always_comb begin
        carry    = (st_q.ms == MS_LAST);
        ms_next  = carry ? '0 : st_q.ms + 1'b1;
        sec_next = st_q.sec + 1'b1;
        st_d     = st_q;
        if (tick_i) begin
            st_d.ms = ms_next;
            if (carry) st_d.sec = sec_next;
        end
        if (sec_load_i) st_d.sec = sec_wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar k = 0; k < NUM_SEC_ALM; k++) begin : g_sec_cmp
        assign sec_hit_o[k] = tick_i && carry && !sec_load_i &&
                              (sec_alm_i[k] != '0) && (sec_next == sec_alm_i[k]);
    end

    assign ms_hit_o = tick_i && (ms_next == ms_alm_i);
    assign sec_o    = st_q.sec;
    assign ms_o     = st_q.ms;
endmodule

// File: rtl/rtc_commit_gate.sv
module rtc_commit_gate #(
    parameter int BUSY_TICKS = 4,
    parameter int CNT_W      = $clog2(BUSY_TICKS + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic wr_req_i,
    output logic accept_o,
    output logic busy_o
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        accept_o = wr_req_i && (st_q.cnt == '0);
        if (accept_o)                      st_d.cnt = LOAD;
        else if (tick_i && st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o = (st_q.cnt != '0);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [INT_W-1:0] event_i,
    input  logic             mask_we_i,
    input  logic             stat_we_i,
    input  logic [INT_W-1:0] wdata_i,
    output logic [INT_W-1:0] mask_o,
    output logic [INT_W-1:0] stat_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [INT_W-1:0] mask;
        logic [INT_W-1:0] stat;
        logic             irq;
    } ic_t;

    ic_t st_d, st_q;
    logic [INT_W-1:0] clr;

    always_comb begin
        st_d      = st_q;
        clr       = stat_we_i ? wdata_i : '0;
        st_d.stat = (st_q.stat & ~clr) | event_i;
        if (mask_we_i) st_d.mask = wdata_i;
        st_d.irq  = |(st_d.stat & st_d.mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign stat_o = st_q.stat;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/rtc_secs_alarm.sv
module rtc_secs_alarm
    import rtc_pkg::*;
#(
    parameter int MS_PER_SEC = 1000,
    parameter int BUSY_TICKS = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int MS_W = $clog2(MS_PER_SEC);

    typedef struct packed {
        logic [NUM_SEC_ALM-1:0][DATA_W-1:0] sec_alm;
        logic [MS_W-1:0]                    ms_alm;
        logic [DATA_W-1:0]                  shadow;
    } top_t;

    top_t st_d, st_q;

    logic                   wr_req, accept, busy, rd_ms;
    logic                   sec_load, mask_we, stat_we;
    logic [DATA_W-1:0]      sec;
    logic [MS_W-1:0]        ms;
    logic [NUM_SEC_ALM-1:0] sec_hit;
    logic                   ms_hit;
    logic [INT_W-1:0]       events, mask, stat;

    assign wr_req = bus_sel_i && bus_wr_i && is_writable(bus_addr_i);
    assign rd_ms  = bus_sel_i && !bus_wr_i && (bus_addr_i == REG_MS);

    rtc_commit_gate #(.BUSY_TICKS(BUSY_TICKS)) u_gate (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .wr_req_i (wr_req),
        .accept_o (accept),
        .busy_o   (busy)
    );

    always_comb begin
        sec_load = accept && (bus_addr_i == REG_SEC);
        mask_we  = accept && (bus_addr_i == REG_MASK);
        stat_we  = accept && (bus_addr_i == REG_STAT);
        st_d     = st_q;
        if (accept && bus_addr_i == REG_ALM0)  st_d.sec_alm[0] = bus_wdata_i;
        if (accept && bus_addr_i == REG_ALM1)  st_d.sec_alm[1] = bus_wdata_i;
        if (accept && bus_addr_i == REG_MSALM) st_d.ms_alm     = bus_wdata_i[MS_W-1:0];
        if (rd_ms)                             st_d.shadow     = sec;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    rtc_timekeeper #(.MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)) u_time (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .sec_load_i  (sec_load),
        .sec_wdata_i (bus_wdata_i),
        .sec_alm_i   (st_q.sec_alm),
        .ms_alm_i    (st_q.ms_alm),
        .sec_o       (sec),
        .ms_o        (ms),
        .sec_hit_o   (sec_hit),
        .ms_hit_o    (ms_hit)
    );

    always_comb begin
        events            = '0;
        events[BIT_ALM0]  = sec_hit[0];
        events[BIT_ALM1]  = sec_hit[1];
        events[BIT_MSALM] = ms_hit;
    end

    rtc_irq_ctrl u_irq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .event_i   (events),
        .mask_we_i (mask_we),
        .stat_we_i (stat_we),
        .wdata_i   (bus_wdata_i[INT_W-1:0]),
        .mask_o    (mask),
        .stat_o    (stat),
        .irq_o     (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            REG_BUSY:   bus_rdata_o = {{(DATA_W-1){1'b0}}, busy};
            REG_SEC:    bus_rdata_o = sec;
            REG_SHADOW: bus_rdata_o = st_q.shadow;
            REG_MS:     bus_rdata_o = DATA_W'(ms);
            REG_ALM0:   bus_rdata_o = st_q.sec_alm[0];
            REG_ALM1:   bus_rdata_o = st_q.sec_alm[1];
            REG_MSALM:  bus_rdata_o = DATA_W'(st_q.ms_alm);
            REG_MASK:   bus_rdata_o = DATA_W'(mask);
            REG_STAT:   bus_rdata_o = DATA_W'(stat);
            default:    bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/rtc_secs_alarm_chk.sv
module rtc_secs_alarm_chk
    import rtc_pkg::*;
#(
    parameter int MS_PER_SEC = 1000,
    parameter int MS_W       = $clog2(MS_PER_SEC)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              wr_req,
    input logic              accept,
    input logic              busy,
    input logic              sec_load,
    input logic              stat_we,
    input logic [DATA_W-1:0] sec,
    input logic [MS_W-1:0]   ms,
    input logic [DATA_W-1:0] alm0,
    input logic [INT_W-1:0]  mask,
    input logic [INT_W-1:0]  stat
);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

    p_ms_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ms <= MS_LAST);

    p_carry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && ms == MS_LAST && !sec_load) |=> (ms == '0 && sec == $past(sec) + 32'd1));

    p_sec_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && ms == MS_LAST && sec == 32'hFFFF_FFFF && !sec_load) |=> (sec == '0));

    p_busy_after_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> busy);

    p_blocked_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_req && busy) |=> ($stable(alm0) && $stable(mask)));

    p_stat_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat[0] && !stat_we) |=> stat[0]);

    p_countdown_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat[4:3] == 2'b00);
endmodule

bind rtc_secs_alarm rtc_secs_alarm_chk #(.MS_PER_SEC(MS_PER_SEC)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .wr_req   (wr_req),
    .accept   (accept),
    .busy     (busy),
    .sec_load (sec_load),
    .stat_we  (stat_we),
    .sec      (sec),
    .ms       (ms),
    .alm0     (st_q.sec_alm[0]),
    .mask     (mask),
    .stat     (stat)
);

// File: tb/tb_rtc_secs_alarm.sv
module tb_rtc_secs_alarm;
    localparam int MSP = 8;
    localparam int BT  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] e_sec, e_shadow, e_a0, e_a1;
    int          e_ms, e_busy;
    logic [2:0]  e_msalm;
    logic [4:0]  e_mask, e_stat;

    always #2 clk = ~clk;

    rtc_secs_alarm #(.MS_PER_SEC(MSP), .BUSY_TICKS(BT)) dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
        if (a == 8'h10) e_shadow = e_sec;
    endtask

    task automatic wrt(input logic [7:0] a, input logic [31:0] d);
        logic ok;
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        ok = (e_busy == 0) && (a == 8'h08 || a == 8'h14 || a == 8'h18 ||
                                a == 8'h1C || a == 8'h28 || a == 8'h2C);
        if (ok) begin
            e_busy = BT;
            case (a)
                8'h08: e_sec = d;
                8'h14: e_a0 = d;
                8'h18: e_a1 = d;
                8'h1C: e_msalm = d[2:0];
                8'h28: e_mask = d[4:0];
                default: e_stat = e_stat & ~d[4:0];
            endcase
        end
    endtask

    task automatic tk();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        if (e_busy > 0) e_busy--;
        if (e_ms == MSP - 1) begin
            e_ms  = 0;
            e_sec = e_sec + 32'd1;
            if (e_a0 != 0 && e_sec == e_a0) e_stat[0] = 1'b1;
            if (e_a1 != 0 && e_sec == e_a1) e_stat[1] = 1'b1;
        end else begin
            e_ms++;
        end
        if (e_ms == int'(e_msalm)) e_stat[2] = 1'b1;
    endtask

    task automatic idle();
        for (int i = 0; i < BT; i++) tk();
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(8'h04, v); chk({tag, " R6 busy"},   v, {31'd0, e_busy != 0});
        rd(8'h08, v); chk({tag, " R4 sec"},    v, e_sec);
        rd(8'h14, v); chk({tag, " R8 alm0"},   v, e_a0);
        rd(8'h18, v); chk({tag, " R8 alm1"},   v, e_a1);
        rd(8'h1C, v); chk({tag, " R9 msalm"},  v, {29'd0, e_msalm});
        rd(8'h28, v); chk({tag, " R11 mask"},  v, {27'd0, e_mask});
        rd(8'h2C, v); chk({tag, " R10 stat"},  v, {27'd0, e_stat});
        chk({tag, " R11 irq"}, {31'd0, irq}, {31'd0, |(e_stat & e_mask)});
        rd(8'h10, v); chk({tag, " R2 ms"},     v, e_ms);
        rd(8'h0C, v); chk({tag, " R5 shadow"}, v, e_shadow);
    endtask

    initial begin
        logic [31:0] v;
        e_sec = '0; e_shadow = '0; e_a0 = '0; e_a1 = '0; e_ms = 0; e_busy = 0;
        e_msalm = '0; e_mask = '0; e_stat = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1");
        // R2 R5: ms sweep with carries
        for (int i = 0; i < 3 * MSP + 2; i++) begin
            tk();
            rd(8'h10, v); chk("R2 ms sweep", v, e_ms);
            rd(8'h0C, v); chk("R5 shadow after ms read", v, e_shadow);
        end
        rd(8'h10, v);
        for (int i = 0; i < MSP; i++) tk();
        rd(8'h0C, v); chk("R5 shadow holds copy", v, e_shadow);
        // R4 R6 R7
        wrt(8'h08, 32'h1234_5678);
        rd(8'h08, v); chk("R4 sec load", v, 32'h1234_5678);
        rd(8'h04, v); chk("R6 busy set", v, 32'd1);
        wrt(8'h14, 32'd5);
        rd(8'h14, v); chk("R7 write while busy ignored", v, 32'd0);
        tk();
        rd(8'h04, v); chk("R6 busy held", v, 32'd1);
        tk();
        rd(8'h04, v); chk("R6 busy released", v, 32'd0);
        // R12: read-only and unmapped writes
        wrt(8'h10, 32'd3); wrt(8'h0C, 32'hDEAD); wrt(8'h04, 32'd1); wrt(8'h30, 32'hFF);
        rd(8'h04, v); chk("R12 no busy from read-only write", v, 32'd0);
        check_all("R12");
        // R3: seconds wrap
        wrt(8'h08, 32'hFFFF_FFFF);
        while (e_sec != 32'd0) tk();
        rd(8'h08, v); chk("R3 sec wrap", v, 32'd0);
        check_all("R3");
        // R8 R10 R11: seconds alarms
        idle();
        wrt(8'h14, e_sec + 32'd3); idle();
        wrt(8'h18, e_sec + 32'd2); idle();
        wrt(8'h28, 32'd1); idle();
        wrt(8'h2C, 32'h1F); idle();
        for (int i = 0; i < 5 * MSP; i++) begin
            tk();
            check_all("R8 R11 sweep");
        end
        wrt(8'h2C, 32'hFFFF_FFFF); idle();
        check_all("R10 clear");
        // R8: alarm value 0 never fires
        wrt(8'h14, 32'd0); idle();
        wrt(8'h2C, 32'h1F); idle();
        wrt(8'h08, 32'hFFFF_FFFF);
        while (e_sec != 32'd0) tk();
        check_all("R8 zero alarm");
        // R9 R11: ms alarm at every position
        for (int p = 0; p < MSP; p++) begin
            idle();
            wrt(8'h1C, p); idle();
            wrt(8'h28, 32'd4); idle();
            wrt(8'h2C, 32'h1F);
            for (int i = 0; i < MSP + 1; i++) begin
                tk();
                check_all("R9 ms alarm");
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule